// File: doc/BRIEF.md
# Shared Cache Maintenance Command Front End

This block sits in front of the engine that performs cache maintenance. Several CPUs share it over a simple single-cycle register bus, and every bus access carries the identifier of the requesting CPU. A CPU posts a maintenance command as a short sequence. It writes the shared mode register, and for address-range work it also writes the shared address and size registers. It then reads its own registration status. That read commits the command to a small in-order FIFO, or it reports why the command was refused. The CPU retries the whole sequence whenever an error bit is set.

Only one CPU may edit the shared command registers at a time. The first write to the mode register claims them, and they stay claimed until the same CPU reads its registration status. Accepted commands go to the back end one at a time through a valid/ready handshake. The back end answers each command with a done pulse. Each CPU has its own queue-status view, which shows whether it has outstanding work, whether one of its commands is executing, and a sticky completion flag.

Two primitive operations are also provided. A drain (sync) stalls a read-back of the primitive register until every accepted command has finished. A prefetch-buffer flush produces a one-cycle pulse on a dedicated output.

Top module: `maint_queue_front`

## Requirements
- R1: When no CPU owns the shared registers, a write to the mode register (offset 0x248) claims them for the writing CPU. While they are owned, mode, address (0x24C) and size (0x250) writes from any other CPU are ignored. A registration-status read (0x25C) by a non-owner returns 0x1 and commits nothing.
- R2: A registration-status read by the owner releases ownership in every case. When it returns 0x0 it commits one command, and after that any CPU may claim the registers.
- R3: The FIFO holds DEPTH commands. An owner read while the FIFO is full returns bit 1 set (0x2) and commits nothing, and the FIFO never exceeds DEPTH entries.
- R4: Mode bits [18:17] select the scope: 0 means address range and 1 means the whole cache. Bits [1:0] select the command: 0 invalidate, 1 clean, 2 flush. Scope 2 or 3, or command 3, makes the owner read return bit 0 set (0x1) with nothing committed.
- R5: A whole-cache command reaches the back end with be_whole=1 and with zero address and size, whatever was written to the address and size registers.
- R6: Commands reach the back end in commit order and one at a time. be_valid stays low from the accepting handshake until the cycle after be_done. While be_valid is high and be_ready is low, the payload holds steady.
- R7: The queue-status register (0x260) read by a CPU has bit 0 set while that CPU has any command queued or executing. Bit 1 is set while that CPU's command is executing.
- R8: Queue-status bit 2 is set when be_done completes a command whose mode bit 15 was set, and only in the issuing CPU's copy. A write with data bit 2 set clears the writer's copy. A set and a clear in the same cycle leave the flag set.
- R9: A write of 0x8 to the primitive register (0x244) starts a drain. A read of 0x244 holds bus_ready low until the FIFO is empty and no command is executing.
- R10: A write of 0x9 to 0x244 drives pf_flush high for exactly the following cycle. Any other value written there, apart from 0x8, has no effect.
- R11: Accesses to unmapped offsets change nothing and read as zero.
- R12: After reset no CPU owns the registers, the FIFO is empty, every status bit is clear, and be_valid and pf_flush are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_cpu | input | CPU_W | Identifier of the requesting CPU |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Low only while a primitive read-back waits for a drain |
| be_valid | output | 1 | Command offered to the back end |
| be_ready | input | 1 | Back end accepts the command |
| be_cmd | output | 2 | 0 invalidate, 1 clean, 2 flush |
| be_whole | output | 1 | Whole-cache scope |
| be_notify | output | 1 | Completion notification requested |
| be_cpu | output | CPU_W | Issuing CPU |
| be_addr | output | 32 | Range start address |
| be_size | output | 32 | Range size |
| be_done | input | 1 | Back end finished the executing command |
| pf_flush | output | 1 | One-cycle prefetch-buffer flush request |

## Verification
The assertions watch, on every cycle, the properties that follow from local state alone. These are that the back end sees one command at a time with a stable payload under backpressure, that ownership persists until the owner reads its status and ends there, that the FIFO never overflows, and that bus stalls and flush pulses have a legitimate source. The bench's scenarios cover the rest. Only they can show the values each CPU reads back: a refused registration from a non-owner, a full queue, illegal mode codes, the per-CPU busy and completion bits with the set-over-clear priority, and the length of a drain stall. A randomized phase with variable back-end latency compares every read and every back-end payload against a behavioural model.

// File: rtl/mqf_pkg.sv
`timescale 1ns/1ps
package mqf_pkg;
  localparam int OFF_W  = 12;
  localparam int DATA_W = 32;

  // register offsets decoded by software
  localparam logic [OFF_W-1:0] OFF_PRIM  = 12'h244;
  localparam logic [OFF_W-1:0] OFF_QMODE = 12'h248;
  localparam logic [OFF_W-1:0] OFF_QADDR = 12'h24C;
  localparam logic [OFF_W-1:0] OFF_QSIZE = 12'h250;
  localparam logic [OFF_W-1:0] OFF_REGST = 12'h25C;
  localparam logic [OFF_W-1:0] OFF_QSTAT = 12'h260;

  localparam logic [DATA_W-1:0] PRIM_DRAIN   = 32'h8;
  localparam logic [DATA_W-1:0] PRIM_PFFLUSH = 32'h9;

  typedef enum logic [1:0] {
    MC_INV   = 2'd0,
    MC_CLEAN = 2'd1,
    MC_FLUSH = 2'd2,
    MC_BAD   = 2'd3
  } maint_op_e;

  typedef struct packed {
    maint_op_e         op;
    logic              whole;
    logic              notify;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] size;
  } maint_cmd_t;
endpackage

// File: rtl/mqf_fifo.sv
`timescale 1ns/1ps
module mqf_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] cnt_n;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = count;
    if (push) wp_n = step(wp_q);
    if (pop)  rp_n = step(rp_q);
    case ({push, pop})
      2'b10:   cnt_n = count + 1'b1;
      2'b01:   cnt_n = count - 1'b1;
      default: cnt_n = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      count <= cnt_n;
    end
  end

  // storage carries no reset; write enable only
  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  assign dout  = mem[rp_q];
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/mqf_claim.sv
`timescale 1ns/1ps
module mqf_claim
  import mqf_pkg::*;
#(
  parameter int CPU_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_addr,
  input  logic              wr_size,
  input  logic              rd_stat,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [DATA_W-1:0] wdata,
  input  logic              q_full,
  output logic              own_vld,
  output logic [CPU_W-1:0]  own_id,
  output logic [DATA_W-1:0] mode_q,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] size_q,
  output logic [1:0]        stat,
  output logic              commit
);
  logic              is_owner, bad;
  logic              own_vld_n;
  logic [CPU_W-1:0]  own_id_n;
  logic [DATA_W-1:0] mode_n, addr_n, size_n;

  assign is_owner = own_vld && (own_id == req_cpu);
  assign bad      = (mode_q[18:17] > 2'd1) || (maint_op_e'(mode_q[1:0]) == MC_BAD);

  always_comb begin
    stat   = is_owner ? {q_full, bad} : 2'b01;
    commit = rd_stat && is_owner && !q_full && !bad;
  end

  always_comb begin
    own_vld_n = own_vld;
    own_id_n  = own_id;
    mode_n    = mode_q;
    addr_n    = addr_q;
    size_n    = size_q;
    if (wr_mode && !own_vld) begin
      own_vld_n = 1'b1;
      own_id_n  = req_cpu;
    end
    if (rd_stat && is_owner) own_vld_n = 1'b0;
    if (wr_mode && (!own_vld || is_owner)) mode_n = wdata;
    if (wr_addr && is_owner)               addr_n = wdata;
    if (wr_size && is_owner)               size_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_id  <= '0;
      mode_q  <= '0;
      addr_q  <= '0;
      size_q  <= '0;
    end else begin
      own_vld <= own_vld_n;
      own_id  <= own_id_n;
      mode_q  <= mode_n;
      addr_q  <= addr_n;
      size_q  <= size_n;
    end
  end
endmodule

// File: rtl/mqf_cpu_status.sv
`timescale 1ns/1ps
module mqf_cpu_status #(
  parameter int N_CPU  = 4,
  parameter int DEPTH  = 4,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1,
  localparam int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CPU_W-1:0] push_cpu,
  input  logic             done,
  input  logic [CPU_W-1:0] done_cpu,
  input  logic             done_notify,
  input  logic             clr,
  input  logic [CPU_W-1:0] clr_cpu,
  output logic [N_CPU-1:0] busy,
  output logic [N_CPU-1:0] cmpl
);
  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             cmpl_q, cmpl_n;
    logic             inc, dec;

    assign inc = push && (push_cpu == CPU_W'(i));
    assign dec = done && (done_cpu == CPU_W'(i));

    always_comb begin
      cnt_n  = cnt_q;
      cmpl_n = cmpl_q;
      if (inc && !dec)      cnt_n = cnt_q + 1'b1;
      else if (dec && !inc) cnt_n = cnt_q - 1'b1;
      // a completion in the same cycle as a clear wins
      if (dec && done_notify)                    cmpl_n = 1'b1;
      else if (clr && (clr_cpu == CPU_W'(i)))    cmpl_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        cmpl_q <= 1'b0;
      end else begin
        cnt_q  <= cnt_n;
        cmpl_q <= cmpl_n;
      end
    end

    assign busy[i] = (cnt_q != '0);
    assign cmpl[i] = cmpl_q;
  end
endmodule

// File: rtl/maint_queue_front.sv
`timescale 1ns/1ps
module maint_queue_front
  import mqf_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int DEPTH  = 4,
  localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [CPU_W-1:0]  bus_cpu,
  input  logic [OFF_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              be_valid,
  input  logic              be_ready,
  output logic [1:0]        be_cmd,
  output logic              be_whole,
  output logic              be_notify,
  output logic [CPU_W-1:0]  be_cpu,
  output logic [DATA_W-1:0] be_addr,
  output logic [DATA_W-1:0] be_size,
  input  logic              be_done,
  output logic              pf_flush
);
  localparam int ENT_W = CPU_W + $bits(maint_cmd_t);
  localparam int QC_W  = $clog2(DEPTH + 1);

  logic wr, rd;
  assign wr = bus_valid && bus_write;
  assign rd = bus_valid && !bus_write;

  // ---- ownership and shared command registers ----
  logic              own_vld, commit;
  logic [CPU_W-1:0]  own_id;
  logic [DATA_W-1:0] mode_q, addr_q, size_q;
  logic [1:0]        reg_stat;
  logic              q_full, q_empty;

  mqf_claim #(.CPU_W(CPU_W)) u_claim (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_mode (wr && bus_addr == OFF_QMODE),
    .wr_addr (wr && bus_addr == OFF_QADDR),
    .wr_size (wr && bus_addr == OFF_QSIZE),
    .rd_stat (rd && bus_addr == OFF_REGST),
    .req_cpu (bus_cpu),
    .wdata   (bus_wdata),
    .q_full  (q_full),
    .own_vld (own_vld),
    .own_id  (own_id),
    .mode_q  (mode_q),
    .addr_q  (addr_q),
    .size_q  (size_q),
    .stat    (reg_stat),
    .commit  (commit)
  );

  // ---- command FIFO ----
  maint_cmd_t       new_cmd, head_cmd;
  logic [CPU_W-1:0] head_cpu;
  logic [QC_W-1:0]  fifo_cnt;
  logic             pop;

  always_comb begin
    new_cmd.op     = maint_op_e'(mode_q[1:0]);
    new_cmd.whole  = (mode_q[18:17] == 2'd1);
    new_cmd.notify = mode_q[15];
    new_cmd.addr   = new_cmd.whole ? '0 : addr_q;
    new_cmd.size   = new_cmd.whole ? '0 : size_q;
  end

  mqf_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (commit),
    .din   ({bus_cpu, new_cmd}),
    .pop   (pop),
    .dout  ({head_cpu, head_cmd}),
    .empty (q_empty),
    .full  (q_full),
    .count (fifo_cnt)
  );

  // ---- back-end issue: one command in flight ----
  logic             inflight_q, inflight_n;
  logic [CPU_W-1:0] cur_cpu_q, cur_cpu_n;
  logic             cur_ntf_q, cur_ntf_n;
  logic             done_ev, idle;

  assign be_valid  = !inflight_q && !q_empty;
  assign pop       = be_valid && be_ready;
  assign done_ev   = inflight_q && be_done;
  assign idle      = q_empty && !inflight_q;
  assign be_cmd    = head_cmd.op;
  assign be_whole  = head_cmd.whole;
  assign be_notify = head_cmd.notify;
  assign be_addr   = head_cmd.addr;
  assign be_size   = head_cmd.size;
  assign be_cpu    = head_cpu;

  always_comb begin
    inflight_n = inflight_q;
    cur_cpu_n  = cur_cpu_q;
    cur_ntf_n  = cur_ntf_q;
    if (pop) begin
      inflight_n = 1'b1;
      cur_cpu_n  = head_cpu;
      cur_ntf_n  = head_cmd.notify;
    end else if (done_ev) begin
      inflight_n = 1'b0;
    end
  end

  // ---- per-CPU status copies ----
  logic [N_CPU-1:0] busy, cmpl;

  mqf_cpu_status #(.N_CPU(N_CPU), .DEPTH(DEPTH)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (commit),
    .push_cpu    (bus_cpu),
    .done        (done_ev),
    .done_cpu    (cur_cpu_q),
    .done_notify (cur_ntf_q),
    .clr         (wr && bus_addr == OFF_QSTAT && bus_wdata[2]),
    .clr_cpu     (bus_cpu),
    .busy        (busy),
    .cmpl        (cmpl)
  );

  // ---- primitives: drain and prefetch flush ----
  logic drain_q, drain_n, pf_n;
  logic prim_wr;

  assign prim_wr = wr && bus_addr == OFF_PRIM;

  always_comb begin
    drain_n = drain_q;
    if (prim_wr && bus_wdata == PRIM_DRAIN) drain_n = 1'b1;
    else if (idle)                          drain_n = 1'b0;
    pf_n = prim_wr && bus_wdata == PRIM_PFFLUSH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
      cur_cpu_q  <= '0;
      cur_ntf_q  <= 1'b0;
      drain_q    <= 1'b0;
      pf_flush   <= 1'b0;
    end else begin
      inflight_q <= inflight_n;
      cur_cpu_q  <= cur_cpu_n;
      cur_ntf_q  <= cur_ntf_n;
      drain_q    <= drain_n;
      pf_flush   <= pf_n;
    end
  end

  assign bus_ready = !(rd && bus_addr == OFF_PRIM && drain_q && !idle);

  // ---- read mux ----
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFF_QMODE: bus_rdata = mode_q;
        OFF_QADDR: bus_rdata = addr_q;
        OFF_QSIZE: bus_rdata = size_q;
        OFF_REGST: bus_rdata = {30'd0, reg_stat};
        OFF_QSTAT: bus_rdata = {29'd0, cmpl[bus_cpu],
                                inflight_q && (cur_cpu_q == bus_cpu), busy[bus_cpu]};
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/mqf_checker.sv
`timescale 1ns/1ps
module mqf_checker
  import mqf_pkg::*;
#(
  parameter int CPU_W = 2,
  parameter int DEPTH = 4,
  parameter int QC_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [CPU_W-1:0]  bus_cpu,
  input logic [OFF_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              be_valid,
  input logic              be_ready,
  input logic [1:0]        be_cmd,
  input logic [CPU_W-1:0]  be_cpu,
  input logic [DATA_W-1:0] be_addr,
  input logic              pf_flush,
  input logic              own_vld,
  input logic [CPU_W-1:0]  own_id,
  input logic [QC_W-1:0]   fifo_cnt
);
  logic owner_reads;
  assign owner_reads = bus_valid && !bus_write && bus_addr == OFF_REGST &&
                       own_vld && own_id == bus_cpu;

  a_r6_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && be_ready) |=> !be_valid);

  a_r6_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (be_valid && !be_ready) |=> (be_valid && $stable(be_cmd) && $stable(be_cpu) && $stable(be_addr)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= QC_W'(DEPTH));

  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    owner_reads |=> !own_vld);

  a_r1_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld && !owner_reads) |=> (own_vld && $stable(own_id)));

  a_r9_stall_source: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (bus_valid && !bus_write && bus_addr == OFF_PRIM));

  a_r10_pf_source: assert property (@(posedge clk) disable iff (!rst_n)
    pf_flush |-> $past(bus_valid && bus_write && bus_addr == OFF_PRIM && bus_wdata == PRIM_PFFLUSH));
endmodule

bind maint_queue_front mqf_checker #(
  .CPU_W (CPU_W),
  .DEPTH (DEPTH),
  .QC_W  (QC_W)
) u_mqf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_cpu   (bus_cpu),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_ready (bus_ready),
  .be_valid  (be_valid),
  .be_ready  (be_ready),
  .be_cmd    (be_cmd),
  .be_cpu    (be_cpu),
  .be_addr   (be_addr),
  .pf_flush  (pf_flush),
  .own_vld   (own_vld),
  .own_id    (own_id),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/maint_queue_front_tb.sv
`timescale 1ns/1ps
module maint_queue_front_tb;
  localparam int NC    = 4;
  localparam int DEPTH = 4;
  localparam int CW    = 2;

  localparam logic [11:0] A_PRIM = 12'h244, A_MODE = 12'h248, A_ADDR = 12'h24C,
                          A_SIZE = 12'h250, A_REGST = 12'h25C, A_QSTAT = 12'h260;

  logic clk, rst_n;
  logic bus_valid, bus_write;
  logic [CW-1:0] bus_cpu;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_ready;
  logic be_valid, be_ready, be_whole, be_notify, be_done, pf_flush;
  logic [1:0] be_cmd;
  logic [CW-1:0] be_cpu;
  logic [31:0] be_addr, be_size;

  maint_queue_front #(.N_CPU(NC), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .be_valid(be_valid),
    .be_ready(be_ready), .be_cmd(be_cmd), .be_whole(be_whole),
    .be_notify(be_notify), .be_cpu(be_cpu), .be_addr(be_addr),
    .be_size(be_size), .be_done(be_done), .pf_flush(pf_flush)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit run_over = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    run_over = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    int cpu; int op; bit whole; bit notify; logic [31:0] addr; logic [31:0] size;
  } ent_t;

  ent_t q[$];
  bit   m_own_vld; int m_own;
  logic [31:0] m_mode, m_addr, m_size;
  bit   m_inflight; int m_cur; bit m_cur_ntf;
  int   m_cnt[NC];
  bit   m_cmpl[NC];
  bit   m_drain, m_pf;

  function automatic bit m_bad();
    return (m_mode[18:17] > 2'd1) || (m_mode[1:0] == 2'd3);
  endfunction

  function automatic bit m_idle();
    return (q.size() == 0) && !m_inflight;
  endfunction

  function automatic logic [31:0] m_read(input int cpu, input logic [11:0] a);
    bit own;
    own = m_own_vld && m_own == cpu;
    case (a)
      A_MODE:  return m_mode;
      A_ADDR:  return m_addr;
      A_SIZE:  return m_size;
      A_REGST: return own ? {30'd0, (q.size() == DEPTH), m_bad()} : 32'h1;
      A_QSTAT: return {29'd0, m_cmpl[cpu], (m_inflight && m_cur == cpu), (m_cnt[cpu] != 0)};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_own_vld = 0; m_own = 0; m_mode = 0; m_addr = 0; m_size = 0;
      m_inflight = 0; m_cur = 0; m_cur_ntf = 0; m_drain = 0; m_pf = 0;
      for (int i = 0; i < NC; i++) begin m_cnt[i] = 0; m_cmpl[i] = 0; end
    end else begin
      bit issue, done, idle, wr, rd, own, push;
      ent_t e;
      int c;
      issue = !m_inflight && q.size() > 0 && be_ready;
      done  = m_inflight && be_done;
      idle  = m_idle();
      wr = bus_valid && bus_write;
      rd = bus_valid && !bus_write;
      c  = int'(bus_cpu);
      own = m_own_vld && m_own == c;
      push = 0;
      if (rd && bus_addr == A_REGST && own) begin
        if (!m_bad() && q.size() < DEPTH) begin
          push = 1;
          e.cpu = c; e.op = int'(m_mode[1:0]); e.whole = (m_mode[18:17] == 2'd1);
          e.notify = m_mode[15];
          e.addr = e.whole ? 32'h0 : m_addr;
          e.size = e.whole ? 32'h0 : m_size;
        end
        m_own_vld = 0;
      end
      if (wr && bus_addr == A_MODE) begin
        if (!m_own_vld) begin m_own_vld = 1; m_own = c; m_mode = bus_wdata; end
        else if (own) m_mode = bus_wdata;
      end
      if (wr && bus_addr == A_ADDR && own) m_addr = bus_wdata;
      if (wr && bus_addr == A_SIZE && own) m_size = bus_wdata;
      if (wr && bus_addr == A_QSTAT && bus_wdata[2]) m_cmpl[c] = 0;
      if (done) begin
        if (m_cur_ntf) m_cmpl[m_cur] = 1;
        m_cnt[m_cur]--;
        m_inflight = 0;
      end
      if (issue) begin
        m_cur = q[0].cpu; m_cur_ntf = q[0].notify;
        void'(q.pop_front());
        m_inflight = 1;
      end
      if (push) begin q.push_back(e); m_cnt[c]++; end
      if (wr && bus_addr == A_PRIM && bus_wdata == 32'h8) m_drain = 1;
      else if (idle) m_drain = 0;
      m_pf = wr && bus_addr == A_PRIM && bus_wdata == 32'h9;
    end
  end

  // per-cycle comparison of the back-end port and stall/pulse outputs
  always @(negedge clk) begin
    #6;
    if (rst_n && !run_over) begin
      bit mv, exp_rdy;
      mv = !m_inflight && q.size() > 0;
      chk(be_valid == mv, "R6 be_valid", be_valid, mv);
      if (mv && be_valid) begin
        chk(int'(be_cpu) == q[0].cpu && int'(be_cmd) == q[0].op, "R6 order cpu/cmd",
            {be_cpu, be_cmd}, q[0].cpu * 4 + q[0].op);
        chk(be_addr == q[0].addr && be_size == q[0].size && be_whole == q[0].whole &&
            be_notify == q[0].notify, "R5 payload", be_addr, q[0].addr);
      end
      chk(pf_flush == m_pf, "R10 pf_flush", pf_flush, m_pf);
      exp_rdy = !(bus_valid && !bus_write && bus_addr == A_PRIM && m_drain && !m_idle());
      chk(bus_ready == exp_rdy, "R9 bus_ready", bus_ready, exp_rdy);
    end
  end

  // ---------------- back-end responder stub ----------------
  bit hold = 0;
  bit hs_q;
  bit rsp_busy;
  int lat;

  always @(posedge clk) hs_q <= rst_n && be_valid && be_ready;

  always @(negedge clk) begin
    if (!rst_n) begin
      be_ready <= 0; be_done <= 0; rsp_busy = 0; lat = 0;
    end else begin
      be_done <= 0;
      if (hs_q) begin rsp_busy = 1; lat = 1 + int'($urandom % 5); end
      if (hold) begin
        be_ready <= 0;
      end else if (rsp_busy) begin
        be_ready <= 0;
        lat--;
        if (lat <= 0) begin be_done <= 1; rsp_busy = 0; end
      end else begin
        be_ready <= ($urandom % 4) != 0;
      end
    end
  end

  // ---------------- bus tasks ----------------
  task automatic bus_wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_cpu = CW'(cpu); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input int cpu, input logic [11:0] a, output logic [31:0] v);
    logic [31:0] e;
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_cpu = CW'(cpu); bus_addr = a; bus_wdata = 0;
    forever begin
      #5;
      if (bus_ready) break;
      @(negedge clk);
    end
    v = bus_rdata;
    e = m_read(cpu, a);
    chk(v == e, (a == A_QSTAT) ? "R7 model read" : "R1 model read", v, e);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic wait_idle();
    while (!m_idle()) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [31:0] v;
    time t0;
    bus_valid = 0; bus_write = 0; bus_cpu = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R12 reset state
    #6;
    chk(be_valid == 0 && pf_flush == 0, "R12 outputs after reset", {be_valid, pf_flush}, 0);
    bus_rd(0, A_QSTAT, v); chk(v == 0, "R12 qstat", v, 0);
    bus_rd(1, A_REGST, v); chk(v == 32'h1, "R12 no owner", v, 1);

    // R1 claim, R2 release
    hold = 1;
    bus_wr(0, A_MODE, 32'h0000_8002);
    bus_wr(0, A_ADDR, 32'h1000);
    bus_wr(0, A_SIZE, 32'h40);
    bus_wr(1, A_MODE, 32'h0002_0001);
    bus_wr(1, A_ADDR, 32'hDEAD);
    bus_rd(2, A_ADDR, v); chk(v == 32'h1000, "R1 foreign addr write ignored", v, 32'h1000);
    bus_rd(2, A_MODE, v); chk(v == 32'h8002, "R1 foreign mode write ignored", v, 32'h8002);
    bus_rd(1, A_REGST, v); chk(v == 32'h1, "R1 non-owner refused", v, 1);
    bus_rd(0, A_REGST, v); chk(v == 32'h0, "R2 owner commit", v, 0);
    #6;
    chk(be_valid && be_addr == 32'h1000 && be_cmd == 2'd2 && be_cpu == 0,
        "R6 committed head", be_addr, 32'h1000);
    bus_rd(0, A_QSTAT, v); chk(v == 32'h1, "R7 busy queued", v, 1);

    // R2 another CPU can claim now; R5 whole scope zeroes range
    bus_wr(1, A_MODE, 32'h0002_0001);
    bus_wr(1, A_ADDR, 32'h5555);
    bus_wr(1, A_SIZE, 32'h77);
    bus_rd(1, A_REGST, v); chk(v == 32'h0, "R2 second CPU commit", v, 0);

    // let head issue, then freeze with it executing
    hold = 0;
    while (!m_inflight) @(negedge clk);
    hold = 1;
    bus_rd(0, A_QSTAT, v); chk(v == 32'h3, "R7 busy+executing", v, 3);
    bus_rd(1, A_QSTAT, v); chk(v == 32'h1, "R7 other CPU queued only", v, 1);
    hold = 0;
    while (m_inflight) @(negedge clk);
    hold = 1;
    repeat (2) @(negedge clk);
    bus_rd(0, A_QSTAT, v); chk(v[2] == 1'b1, "R8 completion set", v, 32'h4);
    if (!m_inflight) begin
      #6; chk(be_valid && be_whole && be_addr == 0 && be_size == 0, "R5 whole scope zeroed",
              be_addr, 0);
    end
    hold = 0;
    wait_idle();
    bus_rd(1, A_QSTAT, v); chk(v == 32'h0, "R8 no notify no completion", v, 0);

    // R8 clear
    bus_wr(0, A_QSTAT, 32'h4);
    bus_rd(0, A_QSTAT, v); chk(v == 32'h0, "R8 cleared by write", v, 0);

    // R3 full queue
    hold = 1;
    for (int k = 0; k < DEPTH; k++) begin
      bus_wr(2, A_MODE, 32'h0);
      bus_wr(2, A_ADDR, 32'h100 * (k + 1));
      bus_wr(2, A_SIZE, 32'h20);
      bus_rd(2, A_REGST, v); chk(v == 32'h0, "R3 fill accepted", v, 0);
    end
    bus_wr(2, A_MODE, 32'h1);
    bus_rd(2, A_REGST, v); chk(v == 32'h2, "R3 full refused", v, 2);
    bus_wr(3, A_MODE, 32'h1);
    bus_rd(3, A_REGST, v); chk(v == 32'h2, "R2 released after full", v, 2);
    hold = 0;
    wait_idle();

    // R4 illegal scope and command
    bus_wr(3, A_MODE, 32'h0004_0000);
    bus_rd(3, A_REGST, v); chk(v == 32'h1, "R4 bad scope", v, 1);
    bus_wr(3, A_MODE, 32'h0000_0003);
    bus_rd(3, A_REGST, v); chk(v == 32'h1, "R4 bad command", v, 1);
    bus_rd(3, A_QSTAT, v); chk(v == 32'h0, "R4 nothing committed", v, 0);

    // R9 drain stall
    hold = 1;
    bus_wr(0, A_MODE, 32'h2);
    bus_rd(0, A_REGST, v); chk(v == 0, "R9 setup commit", v, 0);
    bus_wr(0, A_PRIM, 32'h8);
    t0 = $time;
    fork
      bus_rd(0, A_PRIM, v);
      begin repeat (8) @(negedge clk); hold = 0; end
    join
    chk(($time - t0) >= 160, "R9 read stalled", 32'($time - t0), 160);
    chk(m_idle(), "R9 idle on return", 0, 1);

    // R10 prefetch flush pulse
    bus_wr(1, A_PRIM, 32'h9);
    #6; chk(pf_flush == 1'b1, "R10 pulse high", pf_flush, 1);
    @(negedge clk); #6; chk(pf_flush == 1'b0, "R10 pulse ends", pf_flush, 0);
    bus_wr(1, A_PRIM, 32'h5);
    #6; chk(pf_flush == 1'b0, "R10 other value ignored", pf_flush, 0);
    bus_rd(1, A_PRIM, v); chk(v == 0, "R10 no drain started", v, 0);

    // R11 unmapped
    bus_wr(2, 12'h100, 32'hFFFF_FFFF);
    bus_rd(2, 12'h100, v); chk(v == 0, "R11 unmapped reads zero", v, 0);
    bus_rd(2, A_REGST, v); chk(v == 32'h1, "R11 no claim by unmapped write", v, 1);

    // random phase against the model
    for (int n = 0; n < 600; n++) begin
      int c, s;
      logic [31:0] d;
      c = int'($urandom % NC);
      s = int'($urandom % 10);
      d = {13'd0, 2'($urandom % 3), 1'b0, 1'($urandom % 2), 13'd0, 2'($urandom % 4)};
      case (s)
        0, 1: bus_wr(c, A_MODE, d);
        2:    bus_wr(c, A_ADDR, $urandom);
        3:    bus_wr(c, A_SIZE, $urandom);
        4, 5: bus_rd(c, A_REGST, v);
        6:    bus_rd(c, A_QSTAT, v);
        7:    bus_wr(c, A_QSTAT, 32'h4);
        8:    bus_wr(c, A_PRIM, ($urandom % 2) ? 32'h8 : 32'h9);
        default: bus_rd(c, A_PRIM, v);
      endcase
    end
    wait_idle();
    finish_run();
  end
endmodule